// File: doc/BRIEF.md
# Four-Channel PWM Timer

This block is a 16-bit period timer that drives four pulse-width-modulated outputs. A clock prescaler slows the count rate, a period (reload) register sets the top of the count, and each channel compares the running count with its own compare value to form its output. The count runs either as a sawtooth (edge-aligned: up from zero to the period value, then back to zero) or as a triangle (center-aligned: up to the period value, then down to zero). Each time the count returns to zero the block emits a one-cycle update pulse.

Software configures the timer through a simple synchronous write port. Prescaler, period and alignment writes are held in shadow registers and reach the counter only at an update, or at once while the timer is stopped. Each channel has an output enable, an inversion (polarity) bit, a choice of two compare senses and an optional preload. With preload on, a new compare value waits in a shadow register until the next update, so a pulse width never changes in the middle of a period.

The counter is a four-state machine. `ST_IDLE` (stopped) goes to `ST_EDGE_UP` or `ST_CTR_UP` when the run bit is seen set, choosing by the alignment bit. In `ST_EDGE_UP` the wrap from the period value to zero is the update. In `ST_CTR_UP`, reaching the period value moves to `ST_CTR_DOWN`; in `ST_CTR_DOWN`, arriving at zero is the update. Every update re-selects `ST_EDGE_UP` or `ST_CTR_UP` from the alignment shadow. Any running state returns to `ST_IDLE` when the run bit is seen clear.

Top module: `pwm_timer4`

## Requirements
- R1: After reset every output and the update pulse are 0, the timer is stopped and all configuration registers are 0.
- R2: Edge-aligned mode (address 0 bit 1 = 0): the count rises from 0 to the period value P (address 2) and wraps to 0. A period lasts (P+1)*(S+1) clocks, and `upd_o` is high for the one cycle in which the count has just wrapped to 0.
- R3: The prescaler (address 1, value S) advances the count once every S+1 clocks. S = 0 means it advances on every clock.
- R4: Center-aligned mode (address 0 bit 1 = 1): the count goes 0,1,..,P,P-1,..,1 and repeats, so a period lasts 2*P counts. `upd_o` is high in the cycle in which the count has just come back to 0.
- R5: Channel i has its compare value at address 4+i. In sense A (address 3 bit 8+i = 0) the raw level is high while count < compare. In sense B (bit 8+i = 1) the raw level is inverted.
- R6: A compare value of 0 gives a raw level that never goes high. A compare value above P gives a raw level that never goes low.
- R7: Polarity bit 4+i of address 3 inverts channel i's output.
- R8: Enable bit i of address 3 gates channel i. A disabled channel drives 0.
- R9: With preload bit 12+i of address 3 clear, a compare write is used from the next clock. With it set, the write goes to a shadow register and is used from the next update.
- R10: A preloaded compare write made in the same cycle as an update is not transferred by that update. The update moves the previous shadow value, and the new value waits for the following update.
- R11: Prescaler, period and alignment writes made while running take effect at the next update. The period that is in progress keeps its old length.
- R12: Clearing the run bit (address 0 bit 0) returns the timer to `ST_IDLE`: all outputs go to 0 and the count is cleared. While stopped, the shadows are copied into the working registers on every clock. A restart counts from 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 16 | Configuration write data |
| pwm_o | output | 4 | Channel PWM outputs |
| upd_o | output | 1 | One-cycle update pulse at count return to zero |

## Verification
The two functions that can land in one cycle are the update transfer and a write to a preloaded compare register. The bench provokes this by waiting for an update pulse, stepping to the last count of the period and writing the compare register on exactly that clock. A shadow value written earlier in the same period makes the two possible outcomes differ. The result is judged by counting high cycles over the next two full periods: the first must show the earlier shadow value and the second the value written on the update clock. The same cycle-accurate reference model also covers period, prescaler and alignment writes that meet an update.

// File: rtl/pwm_tmr_pkg.sv
`timescale 1ns/1ps
package pwm_tmr_pkg;

    // Counter sequencing states
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_EDGE_UP  = 2'd1,
        ST_CTR_UP   = 2'd2,
        ST_CTR_DOWN = 2'd3
    } tmr_state_e;

    // Register addresses
    localparam int A_CTRL  = 0;
    localparam int A_PSC   = 1;
    localparam int A_ARR   = 2;
    localparam int A_CHCFG = 3;
    localparam int A_CMP0  = 4;

    // Control word bit positions
    localparam int CTRL_RUN_BIT = 0;
    localparam int CTRL_CTR_BIT = 1;

endpackage

// File: rtl/pwm_tmr_regs.sv
`timescale 1ns/1ps
module pwm_tmr_regs
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int N_CH   = 4,
    parameter int ADDR_W = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [CNT_W-1:0]            wdata,
    input  logic                        load,
    input  logic                        idle,
    output logic                        run,
    output logic                        align,
    output logic [CNT_W-1:0]            psc_shd,
    output logic [CNT_W-1:0]            arr_shd,
    output logic [N_CH-1:0]             en,
    output logic [N_CH-1:0]             pol,
    output logic [N_CH-1:0]             mode,
    output logic [N_CH-1:0]             pre,
    output logic [N_CH-1:0][CNT_W-1:0]  cmp_act
);

    logic hit_ctrl, hit_psc, hit_arr, hit_cfg;

    always_comb begin
        hit_ctrl = we && (addr == ADDR_W'(A_CTRL));
        hit_psc  = we && (addr == ADDR_W'(A_PSC));
        hit_arr  = we && (addr == ADDR_W'(A_ARR));
        hit_cfg  = we && (addr == ADDR_W'(A_CHCFG));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run     <= 1'b0;
            align   <= 1'b0;
            psc_shd <= '0;
            arr_shd <= '0;
            en      <= '0;
            pol     <= '0;
            mode    <= '0;
            pre     <= '0;
        end else begin
            if (hit_ctrl) begin
                run   <= wdata[CTRL_RUN_BIT];
                align <= wdata[CTRL_CTR_BIT];
            end
            if (hit_psc) psc_shd <= wdata;
            if (hit_arr) arr_shd <= wdata;
            if (hit_cfg) begin
                en   <= wdata[N_CH-1:0];
                pol  <= wdata[2*N_CH-1:N_CH];
                mode <= wdata[3*N_CH-1:2*N_CH];
                pre  <= wdata[4*N_CH-1:3*N_CH];
            end
        end
    end

    // Per-channel compare shadow and working registers
    for (genvar gi = 0; gi < N_CH; gi++) begin : gen_cmp
        logic             hit;
        logic [CNT_W-1:0] shd_q;

        assign hit = we && (addr == ADDR_W'(A_CMP0 + gi));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shd_q       <= '0;
                cmp_act[gi] <= '0;
            end else begin
                if (load && (idle || pre[gi])) cmp_act[gi] <= shd_q;
                if (hit) begin
                    shd_q <= wdata;
                    if (!pre[gi]) cmp_act[gi] <= wdata;
                end
            end
        end
    end

endmodule

// File: rtl/pwm_tmr_core.sv
`timescale 1ns/1ps
module pwm_tmr_core
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             align,
    input  logic [CNT_W-1:0] psc_shd,
    input  logic [CNT_W-1:0] arr_shd,
    output tmr_state_e       st,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] arr_act,
    output logic             tick,
    output logic             load,
    output logic             upd
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    tmr_state_e       st_q, st_n, top_st;
    logic [CNT_W-1:0] cnt_q, cnt_n, pc_q, pc_n, psc_act;
    logic             wrap;

    // Next-state and next-count decision
    always_comb begin
        st_n   = st_q;
        cnt_n  = cnt_q;
        pc_n   = pc_q;
        wrap   = 1'b0;
        top_st = align ? ST_CTR_UP : ST_EDGE_UP;
        tick   = (st_q != ST_IDLE) && (pc_q == psc_act);
        unique case (st_q)
            ST_IDLE: begin
                cnt_n = '0;
                pc_n  = '0;
                if (run) st_n = top_st;
            end
            ST_EDGE_UP, ST_CTR_UP, ST_CTR_DOWN: begin
                if (!run) begin
                    st_n  = ST_IDLE;
                    cnt_n = '0;
                    pc_n  = '0;
                end else if (!tick) begin
                    pc_n = pc_q + ONE;
                end else begin
                    pc_n = '0;
                    if (st_q == ST_EDGE_UP) begin
                        if (cnt_q >= arr_act) begin
                            cnt_n = '0;
                            wrap  = 1'b1;
                        end else begin
                            cnt_n = cnt_q + ONE;
                        end
                    end else if (st_q == ST_CTR_UP) begin
                        if (cnt_q >= arr_act) begin
                            if (cnt_q <= ONE) begin
                                cnt_n = '0;
                                wrap  = 1'b1;
                            end else begin
                                cnt_n = cnt_q - ONE;
                                st_n  = ST_CTR_DOWN;
                            end
                        end else begin
                            cnt_n = cnt_q + ONE;
                        end
                    end else begin
                        if (cnt_q <= ONE) begin
                            cnt_n = '0;
                            wrap  = 1'b1;
                        end else begin
                            cnt_n = cnt_q - ONE;
                        end
                    end
                    if (wrap) st_n = top_st;
                end
            end
            default: st_n = ST_IDLE;
        endcase
        load = (st_q == ST_IDLE) || wrap;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_n;
    end

    // Count, prescale and working-register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            pc_q    <= '0;
            psc_act <= '0;
            arr_act <= '0;
            upd     <= 1'b0;
        end else begin
            cnt_q <= cnt_n;
            pc_q  <= pc_n;
            upd   <= wrap;
            if (load) begin
                psc_act <= psc_shd;
                arr_act <= arr_shd;
            end
        end
    end

    assign st  = st_q;
    assign cnt = cnt_q;

endmodule

// File: rtl/pwm_tmr_chan.sv
`timescale 1ns/1ps
module pwm_tmr_chan #(
    parameter int CNT_W = 16
) (
    input  logic             running,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    input  logic             en,
    input  logic             pol,
    input  logic             mode,
    output logic             pwm
);

    logic below;

    always_comb begin
        below = (cnt < cmp);
        pwm   = running && en && (below ^ mode ^ pol);
    end

endmodule

// File: rtl/pwm_timer4.sv
`timescale 1ns/1ps
module pwm_timer4
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int N_CH  = 4,
    localparam int ADDR_W = $clog2(A_CMP0 + N_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CNT_W-1:0]  cfg_wdata,
    output logic [N_CH-1:0]   pwm_o,
    output logic              upd_o
);

    tmr_state_e                st;
    logic                      run, align, tick, load, idle;
    logic [CNT_W-1:0]          psc_shd, arr_shd, arr_act, cnt;
    logic [N_CH-1:0]           en, pol, mode, pre;
    logic [N_CH-1:0][CNT_W-1:0] cmp_act;

    assign idle = (st == ST_IDLE);

    pwm_tmr_regs #(.CNT_W(CNT_W), .N_CH(N_CH), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .load    (load),
        .idle    (idle),
        .run     (run),
        .align   (align),
        .psc_shd (psc_shd),
        .arr_shd (arr_shd),
        .en      (en),
        .pol     (pol),
        .mode    (mode),
        .pre     (pre),
        .cmp_act (cmp_act)
    );

    pwm_tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .align   (align),
        .psc_shd (psc_shd),
        .arr_shd (arr_shd),
        .st      (st),
        .cnt     (cnt),
        .arr_act (arr_act),
        .tick    (tick),
        .load    (load),
        .upd     (upd_o)
    );

    for (genvar gc = 0; gc < N_CH; gc++) begin : gen_ch
        pwm_tmr_chan #(.CNT_W(CNT_W)) u_ch (
            .running (!idle),
            .cnt     (cnt),
            .cmp     (cmp_act[gc]),
            .en      (en[gc]),
            .pol     (pol[gc]),
            .mode    (mode[gc]),
            .pwm     (pwm_o[gc])
        );
    end

endmodule

// File: rtl/pwm_timer4_chk.sv
`timescale 1ns/1ps
module pwm_timer4_chk
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int N_CH  = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input tmr_state_e                 st,
    input logic [CNT_W-1:0]           cnt,
    input logic [CNT_W-1:0]           arr_act,
    input logic                       run,
    input logic                       tick,
    input logic                       load,
    input logic [N_CH-1:0]            en,
    input logic [N_CH-1:0]            pre,
    input logic [N_CH-1:0][CNT_W-1:0] cmp_act,
    input logic [N_CH-1:0]            pwm_o,
    input logic                       upd_o
);

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (pwm_o == '0));

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |-> (cnt <= arr_act));

    // R4
    upd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |-> (cnt == '0));

    // R4
    ctr_down_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CTR_DOWN) |-> (cnt != '0));

    // R3
    psc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st != ST_IDLE) && run && !tick) |=> $stable(cnt));

    // R8
    dis_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwm_o & ~en) == '0));

    for (genvar gk = 0; gk < N_CH; gk++) begin : gen_pre
        // R9
        pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pre[gk] && !load) |=> $stable(cmp_act[gk]));
    end

endmodule

bind pwm_timer4 pwm_timer4_chk #(.CNT_W(CNT_W), .N_CH(N_CH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .st      (st),
    .cnt     (cnt),
    .arr_act (arr_act),
    .run     (run),
    .tick    (tick),
    .load    (load),
    .en      (en),
    .pre     (pre),
    .cmp_act (cmp_act),
    .pwm_o   (pwm_o),
    .upd_o   (upd_o)
);

// File: tb/tb_pwm_timer4.sv
`timescale 1ns/1ps
module tb_pwm_timer4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [3:0]  pwm_o;
    logic        upd_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    int hi [4];
    int nu;

    always #4 clk = ~clk;

    pwm_timer4 dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pwm_o(pwm_o), .upd_o(upd_o)
    );

    // Behavioural reference model (phase: 0 stopped, 1 sawtooth, 2 rising, 3 falling)
    int m_ph, m_cnt, m_pc, m_psc, m_arr, m_psc_s, m_arr_s;
    bit m_run, m_align, m_upd;
    bit [3:0] m_en, m_pol, m_mode, m_pre;
    int m_cact [4];
    int m_cshd [4];

    task automatic model_reset();
        m_ph = 0; m_cnt = 0; m_pc = 0; m_psc = 0; m_arr = 0;
        m_psc_s = 0; m_arr_s = 0; m_run = 0; m_align = 0; m_upd = 0;
        m_en = 0; m_pol = 0; m_mode = 0; m_pre = 0;
        foreach (m_cact[k]) begin m_cact[k] = 0; m_cshd[k] = 0; end
    endtask

    initial model_reset();

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            int  was_ph;
            bit  wrapped;
            was_ph  = m_ph;
            wrapped = 0;
            if (m_ph == 0) begin
                m_cnt = 0; m_pc = 0;
                if (m_run) m_ph = m_align ? 2 : 1;
            end else if (!m_run) begin
                m_ph = 0; m_cnt = 0; m_pc = 0;
            end else if (m_pc != m_psc) begin
                m_pc++;
            end else begin
                m_pc = 0;
                if (m_ph == 1) begin
                    if (m_cnt >= m_arr) wrapped = 1; else m_cnt++;
                end else if (m_ph == 2) begin
                    if (m_cnt < m_arr) m_cnt++;
                    else if (m_cnt <= 1) wrapped = 1;
                    else begin m_cnt--; m_ph = 3; end
                end else begin
                    if (m_cnt <= 1) wrapped = 1; else m_cnt--;
                end
                if (wrapped) begin m_cnt = 0; m_ph = m_align ? 2 : 1; end
            end
            m_upd = wrapped;
            if (was_ph == 0 || wrapped) begin
                m_psc = m_psc_s;
                m_arr = m_arr_s;
                for (int k = 0; k < 4; k++)
                    if (was_ph == 0 || m_pre[k]) m_cact[k] = m_cshd[k];
            end
            if (cfg_we) begin
                case (cfg_addr)
                    3'd0: begin m_run = cfg_wdata[0]; m_align = cfg_wdata[1]; end
                    3'd1: m_psc_s = int'(cfg_wdata);
                    3'd2: m_arr_s = int'(cfg_wdata);
                    3'd3: begin
                        m_en = cfg_wdata[3:0]; m_pol = cfg_wdata[7:4];
                        m_mode = cfg_wdata[11:8]; m_pre = cfg_wdata[15:12];
                    end
                    default: begin
                        m_cshd[cfg_addr - 3'd4] = int'(cfg_wdata);
                        if (!m_pre[cfg_addr - 3'd4]) m_cact[cfg_addr - 3'd4] = int'(cfg_wdata);
                    end
                endcase
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Compare with the model on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [3:0] e;
            for (int k = 0; k < 4; k++)
                e[k] = (m_ph != 0) && m_en[k] &&
                       (((m_cnt < m_cact[k]) ? 1'b1 : 1'b0) ^ m_mode[k] ^ m_pol[k]);
            chk("R5 per-cycle outputs", int'(pwm_o), int'(e));
            chk("R2 per-cycle update", int'(upd_o), int'(m_upd));
        end
    end

    task automatic wr(input int a, input int d);
        cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 16'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic measure(input int n);
        foreach (hi[k]) hi[k] = 0;
        nu = 0;
        for (int s = 0; s < n; s++) begin
            for (int c = 0; c < 4; c++) if (pwm_o[c]) hi[c]++;
            if (upd_o) nu++;
            @(negedge clk);
        end
    endtask

    task automatic wait_upd();
        while (!upd_o) @(negedge clk);
    endtask

    task automatic gap(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!upd_o);
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", int'(pwm_o), 0);
        chk("R1 reset update", int'(upd_o), 0);
        rst_n = 1'b1;
        measure(8);
        chk("R1 idle after reset updates", nu, 0);

        // Edge-aligned, P=7, S=0
        wr(1, 0); wr(2, 7);
        wr(4, 2); wr(5, 0); wr(6, 9); wr(7, 8);
        wr(3, 16'h000F);
        wr(0, 1);
        repeat (2) @(negedge clk);
        measure(32);
        chk("R2 updates per 32 clocks", nu, 4);
        chk("R5 ch0 25pct duty", hi[0], 8);
        chk("R6 compare zero low", hi[1], 0);
        chk("R6 compare above period high", hi[2], 32);
        chk("R6 compare P+1 high", hi[3], 32);
        wait_upd(); gap(n);
        chk("R2 edge period", n, 8);

        // Polarity, sense B, disable
        wr(3, 16'h021B);
        @(negedge clk);
        measure(32);
        chk("R7 inverted ch0", hi[0], 24);
        chk("R5 sense B ch1", hi[1], 32);
        chk("R8 disabled ch2", hi[2], 0);

        // Prescaler
        wr(3, 16'h000F);
        wr(1, 2); wr(2, 3);
        repeat (40) @(negedge clk);
        measure(48);
        chk("R3 updates with prescale", nu, 4);
        chk("R3 ch0 prescaled duty", hi[0], 24);
        chk("R3 ch3 high", hi[3], 48);

        // Period write in mid-run
        wait_upd();
        wr(2, 5);
        gap(n);
        chk("R11 old period kept", n + 1, 12);
        gap(n);
        chk("R11 new period", n, 18);

        // Center-aligned, P=4
        wr(1, 0); wr(2, 4); wr(0, 3);
        wr(4, 2); wr(5, 0); wr(6, 5); wr(7, 4);
        repeat (60) @(negedge clk);
        wait_upd(); gap(n);
        chk("R4 center period", n, 8);
        measure(32);
        chk("R4 center updates", nu, 4);
        chk("R4 center ch0", hi[0], 12);
        chk("R6 center compare zero", hi[1], 0);
        chk("R6 center compare above", hi[2], 32);
        chk("R4 center ch3", hi[3], 28);

        // Preload, edge-aligned P=7
        wr(0, 1); wr(2, 7); wr(4, 2);
        repeat (40) @(negedge clk);
        wr(3, 16'h100F);
        wait_upd();
        wr(4, 6);
        measure(7);
        chk("R9 preload old value held", hi[0], 1);
        measure(8);
        chk("R9 preload value at update", hi[0], 6);

        // Compare write in the update cycle
        wait_upd();
        repeat (2) @(negedge clk);
        wr(4, 4);
        repeat (4) @(negedge clk);
        wr(4, 3);
        measure(8);
        chk("R10 update moves earlier shadow", hi[0], 4);
        measure(8);
        chk("R10 late value next period", hi[0], 3);

        // Halt and restart
        wr(0, 0);
        @(negedge clk);
        measure(16);
        chk("R12 halted ch3", hi[3], 0);
        chk("R12 halted ch0", hi[0], 0);
        chk("R12 halted updates", nu, 0);
        wr(0, 1);
        gap(n);
        chk("R12 restart from zero", n, 9);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule